// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block is a clocked controller placed between an internal single-word request interface and an external asynchronous static RAM of 262,144 words by 16 bits. A request carries a direction, an 18-bit word address, write data and a two-bit byte-enable. The controller turns it into a complete RAM cycle. That cycle drives an active-low chip select, a write strobe, an output enable and one active-low strobe per byte lane. Each phase is held for a cycle count that is derived from nanosecond minimums and a configurable clock period.

The data bus is split into an output word, a drive-enable and an input word, so that the pad tristate stays outside the block. The controller turns on its drivers only while the write strobe is low. It keeps output enable high for the whole write, which lets the shorter write pulse apply. It never lowers output enable in the cycle directly after it has driven the bus. Read data is registered at the end of the access window and returned with a one-cycle response pulse. Byte lanes that were not enabled come back as zero.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: In reset, and in the first cycle after it, the following hold: chip select, write strobe, output enable and both byte strobes are high; the bus drive-enable is low; `req_ready` is high; `rsp_valid` is low.
- R2: `req_ready` is high only when the controller is idle. It is low from the cycle after a request is accepted until the RAM cycle has finished. A write returns to ready on the fifth falling edge after acceptance, and a read returns on the fourth.
- R3: A read lowers chip select and output enable for RD_CYC = ceil(max(tAA, tRC) / clock period) cycles, which is 3 at the default values. It samples the bus at the end of the last such cycle. It then raises `rsp_valid` for exactly one cycle, the cycle after the window.
- R4: A write has three phases. First comes one setup cycle with chip select low and the write strobe high. Next the write strobe is low for WP_CYC = ceil(max(tWP, tDW, tCW) / clock period) cycles, which is 2 at the default values. Last comes one recovery cycle with the write strobe high and chip select still low.
- R5: The bus drive-enable is high only while the write strobe is low, and the driven word equals the request's write data.
- R6: Output enable stays high in every cycle where the write strobe is low.
- R7: Output enable never falls in the cycle that directly follows a cycle with the bus drive-enable high.
- R8: Request byte-enable bit 0 maps to byte strobe bit 0, which is active low and covers data bits 7:0. Bit 1 maps to strobe bit 1, which covers bits 15:8. In a write, a lane whose enable is 0 leaves that byte of the RAM word unchanged.
- R9: In a read, each lane whose byte-enable is 0 returns 8'h00 in `rsp_rdata`, whatever is on the bus.
- R10: A request with byte-enable 2'b00 still runs a full cycle and still completes. As a write it changes no RAM data. As a read it returns 16'h0000.
- R11: The RAM address equals the full 18-bit request address and is held stable for every cycle that chip select is low, including the highest address 18'h3FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, active high, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_be_n | output | 2 | RAM byte strobes, active low, bit 0 = low byte |
| mem_dq_o | output | 16 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive-enable for mem_dq_o |
| mem_dq_i | input | 16 | Data received from the RAM |

## Verification
The hardest case to reach from the ports is a read issued too early. If the access window were one cycle short, a RAM model that returns data at once would hide the fault. The bench model therefore presents a filler pattern until chip select and output enable have been low for the full access count, so an early capture returns visibly wrong data. Bus turnaround is exercised by write-then-read pairs issued as soon as ready returns. The bench also mixes partial and empty byte masks on both directions, so that lane gating on the write strobes and on the returned data shows at the outputs.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared state encoding and compile-time helpers for the
// asynchronous SRAM cycle controller. Assumes positive integer inputs.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACC
    } ctrl_state_t;

    // Integer division rounded up, used to turn picoseconds into cycles.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two integers.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
// Phase timer: loads a cycle count minus one and counts down to zero.
// done is high in the final cycle of the loaded phase. Assumes that load
// is asserted on the edge that starts the phase.
module sram_cycle_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_gate.sv
// Byte-lane gate: passes each lane of din whose enable bit is set and
// forces the other lanes to zero. Assumes that lane 0 is the least
// significant lane.
module sram_lane_gate #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] din,
    input  logic [LANES-1:0]        en,
    output logic [LANES*LANE_W-1:0] dout
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One lane: pass when enabled, zero otherwise.
        assign dout[g*LANE_W +: LANE_W] = en[g] ? din[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/sram_cycle_ctrl.sv
// Asynchronous SRAM cycle controller. It accepts one request at a time and
// plays out a timed read or write on an asynchronous static RAM. All RAM
// controls are registered. Phase lengths are cycle counts rounded up from
// nanosecond minimums expressed in picoseconds. Assumptions: the RAM needs
// zero address setup and zero write recovery; the pad tristate sits outside
// and is steered by mem_dq_oe.
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 16,
    parameter int LANE_W        = 8,
    parameter int CLK_PERIOD_PS = 4000,
    parameter int T_AA_PS       = 10000,
    parameter int T_RC_PS       = 10000,
    parameter int T_WP_PS       = 7000,
    parameter int T_DW_PS       = 5000,
    parameter int T_CW_PS       = 7000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [DATA_W/LANE_W-1:0] req_be,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_cs_n,
    output logic                     mem_we_n,
    output logic                     mem_oe_n,
    output logic [DATA_W/LANE_W-1:0] mem_be_n,
    output logic [DATA_W-1:0]        mem_dq_o,
    output logic                     mem_dq_oe,
    input  logic [DATA_W-1:0]        mem_dq_i
);

    localparam int LANES  = DATA_W / LANE_W;
    localparam int RD_CYC = max2(1, ceil_div(max2(T_AA_PS, T_RC_PS), CLK_PERIOD_PS));
    localparam int WP_CYC = max2(1, ceil_div(max2(max2(T_WP_PS, T_DW_PS), T_CW_PS),
                                             CLK_PERIOD_PS));
    localparam int CNT_W  = max2(1, $clog2(max2(RD_CYC, WP_CYC) + 1));

    ctrl_state_t       state_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic [DATA_W-1:0] rd_gated;

    // Ready whenever the controller is idle.
    assign req_ready = (state_q == ST_IDLE);

    // Timer load: access length on read accept, pulse length at write setup.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (state_q == ST_IDLE && req_valid && !req_write) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RD_CYC - 1);
        end else if (state_q == ST_WSETUP) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(WP_CYC - 1);
        end
    end

    sram_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_lane_gate #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_gate (
        .din  (mem_dq_i),
        .en   (~mem_be_n),
        .dout (rd_gated)
    );

    // Cycle sequencer: steps through phases and drives every RAM control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mem_addr  <= '0;
            mem_cs_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_be_n  <= '1;
            mem_dq_o  <= '0;
            mem_dq_oe <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        mem_addr <= req_addr;
                        mem_be_n <= ~req_be;
                        mem_cs_n <= 1'b0;
                        if (req_write) begin
                            mem_dq_o <= req_wdata;
                            state_q  <= ST_WSETUP;
                        end else begin
                            mem_oe_n <= 1'b0;
                            state_q  <= ST_RACC;
                        end
                    end
                end
                ST_WSETUP: begin
                    mem_we_n  <= 1'b0;
                    mem_dq_oe <= 1'b1;
                    state_q   <= ST_WPULSE;
                end
                ST_WPULSE: begin
                    if (tmr_done) begin
                        mem_we_n  <= 1'b1;
                        mem_dq_oe <= 1'b0;
                        state_q   <= ST_WHOLD;
                    end
                end
                ST_WHOLD: begin
                    mem_cs_n <= 1'b1;
                    mem_be_n <= '1;
                    state_q  <= ST_IDLE;
                end
                ST_RACC: begin
                    if (tmr_done) begin
                        rsp_rdata <= rd_gated;
                        rsp_valid <= 1'b1;
                        mem_cs_n  <= 1'b1;
                        mem_oe_n  <= 1'b1;
                        mem_be_n  <= '1;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sram_ctrl_checker.sv
// Protocol checker for the SRAM cycle controller, bound to its top module.
// It observes ports only and assumes a synchronous active-low reset.
module sram_ctrl_checker #(
    parameter int ADDR_W = 18,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [LANES-1:0]  mem_be_n,
    input logic              mem_dq_oe
);

    AST_DRIVE_ONLY_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);                                   // R5

    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);                                    // R6

    AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |=> mem_oe_n);                                    // R7

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                  // R3

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready);                                  // R2

    AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);                                   // R4

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));     // R11

    AST_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (mem_be_n == '1));                             // R8

endmodule

bind sram_cycle_ctrl sram_ctrl_checker #(
    .ADDR_W (ADDR_W),
    .LANES  (DATA_W / LANE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_cycle_ctrl.sv
// Bench: vector table of requests with a RAM model that withholds read data
// until the access time is met, then directed reset and monitor checks.
module sim_sram_cycle_ctrl;

    localparam int CLK_PS = 4000;
    localparam int RD     = (10000 + CLK_PS - 1) / CLK_PS;
    localparam int WP     = (7000 + CLK_PS - 1) / CLK_PS;

    typedef struct packed {
        logic        wr;
        logic [17:0] addr;
        logic [15:0] data;
        logic [1:0]  be;
    } vec_t;

    // data = write data for writes, expected rsp_rdata for reads
    localparam vec_t VEC [0:11] = '{
        '{1'b1, 18'h00010, 16'h1234, 2'b11},
        '{1'b0, 18'h00010, 16'h1234, 2'b11},
        '{1'b1, 18'h00010, 16'hABCD, 2'b01},
        '{1'b0, 18'h00010, 16'h12CD, 2'b11},
        '{1'b0, 18'h00010, 16'h1200, 2'b10},
        '{1'b1, 18'h00020, 16'h5566, 2'b10},
        '{1'b0, 18'h00020, 16'h5500, 2'b11},
        '{1'b1, 18'h3FFFF, 16'hFFFF, 2'b11},
        '{1'b0, 18'h3FFFF, 16'hFFFF, 2'b11},
        '{1'b1, 18'h00030, 16'h7777, 2'b00},
        '{1'b0, 18'h00030, 16'h0000, 2'b11},
        '{1'b0, 18'h00010, 16'h0000, 2'b00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [15:0] rsp_rdata, mem_dq_o, mem_dq_i;
    logic [17:0] mem_addr;
    logic [1:0]  mem_be_n;

    int total = 0, bad = 0;
    logic [15:0] ram [0:255];
    int acc_cnt = 0, wlen = 0, last_wlen = 0, olen = 0, last_olen = 0;
    int v_drive = 0, v_oe = 0, v_turn = 0;
    logic prev_dq_oe = 1'b0;
    logic mon_en = 1'b0;

    always #5 clk = ~clk;

    sram_cycle_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // RAM model read path: filler until access time met, 8'hEE on off lanes
    always_comb begin
        mem_dq_i = 16'hBEEF;
        if (!mem_cs_n && !mem_oe_n && mem_we_n && acc_cnt >= RD) begin
            for (int l = 0; l < 2; l++)
                mem_dq_i[l*8 +: 8] = mem_be_n[l] ? 8'hEE : ram[mem_addr[7:0]][l*8 +: 8];
        end
    end

    // RAM model write path and protocol monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (!mem_cs_n && !mem_we_n && mem_dq_oe)
            for (int l = 0; l < 2; l++)
                if (!mem_be_n[l]) ram[mem_addr[7:0]][l*8 +: 8] = mem_dq_o[l*8 +: 8];
        acc_cnt = (!mem_cs_n && !mem_oe_n && mem_we_n) ? acc_cnt + 1 : 0;
        if (mon_en) begin
            if (mem_dq_oe && mem_we_n) v_drive++;
            if (!mem_we_n && !mem_oe_n) v_oe++;
            if (!mem_oe_n && prev_dq_oe) v_turn++;
        end
        prev_dq_oe = mem_dq_oe;
        if (!mem_we_n) wlen++;
        else if (wlen != 0) begin last_wlen = wlen; wlen = 0; end
        if (!mem_oe_n) olen++;
        else if (olen != 0) begin last_olen = olen; olen = 0; end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input vec_t v);
        int n;
        @(negedge clk);
        chk(req_ready === 1'b1, "R2 ready when idle", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = v.wr; req_addr = v.addr;
        req_wdata = v.data; req_be = v.be;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        chk(mem_addr == v.addr, "R11 address", 32'(mem_addr), 32'(v.addr));
        chk(mem_be_n == ~v.be, "R8 strobes", 32'(mem_be_n), 32'(~v.be));
        chk(req_ready == 1'b0, "R2 busy", 32'(req_ready), 0);
        if (v.wr) begin
            chk(mem_we_n && !mem_cs_n, "R4 setup phase", 32'(mem_we_n), 1);
            while (!req_ready && n < 50) begin
                @(negedge clk); n++;
                if (!mem_cs_n)
                    chk(mem_addr == v.addr, "R11 address held", 32'(mem_addr), 32'(v.addr));
                if (mem_dq_oe)
                    chk(mem_dq_o == v.data, "R5 write data", 32'(mem_dq_o), 32'(v.data));
            end
            chk(n == 5, "R2 R4 write length", n, 5);
            chk(last_wlen == WP, "R4 write pulse", last_wlen, WP);
        end else begin
            while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
            chk(n == 4, "R3 read latency", n, 4);
            chk(rsp_rdata == v.data, "R3 R9 R10 read data", 32'(rsp_rdata), 32'(v.data));
            @(negedge clk);
            chk(!rsp_valid, "R3 single pulse", 32'(rsp_valid), 0);
            chk(last_olen == RD, "R3 access window", last_olen, RD);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports
    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = 16'h0000;
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
            "R1 controls in reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_be_n}, 5'h1F);
        chk(req_ready && !rsp_valid, "R1 handshake in reset", {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        chk(mem_cs_n && !mem_dq_oe && req_ready, "R1 after reset",
            {mem_cs_n, mem_dq_oe, req_ready}, 3'b101);

        for (int k = 0; k < 12; k++) run(VEC[k]);

        // R10: empty-mask write left the word unchanged, seen through a read
        run('{1'b0, 18'h00030, 16'h0000, 2'b11});

        // R1: reset in the middle of a read returns to idle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00010; req_be = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(mem_cs_n && mem_oe_n && req_ready && !rsp_valid, "R1 reset mid cycle",
            {mem_cs_n, mem_oe_n, req_ready, rsp_valid}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);

        chk(v_drive == 0, "R5 drive only in pulse", v_drive, 0);
        chk(v_oe == 0, "R6 output enable in write", v_oe, 0);
        chk(v_turn == 0, "R7 turnaround gap", v_turn, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule